// File: doc/BRIEF.md
# External Bus Byte-Lane Alignment Unit

This block sits between a 32-bit internal master and a 32-bit external memory bus. It takes one request at a time: a byte address, a transfer size (byte, word or longword), a direction flag and right-justified write data. For each accepted request it runs a single registered bus phase. In that phase it drives the longword-aligned address, four active-low lane strobes, one active-low common write strobe and write data with the addressed bytes placed on the correct lanes. Lane order is big-endian: byte offset 0 lives on the most significant lane.

A mode input picks how the strobes behave. In per-lane write mode the lane strobes act only as write enables, and a read leaves them all high. In common-strobe mode the lane strobes mark the target lanes for reads and writes alike, and a write also pulls the common write strobe low. Read data is taken from the bus at the end of the bus phase, moved down to bit 0, zero-filled above the access size and returned with a one-cycle valid pulse. A request whose address does not suit its size is rejected with a one-cycle error pulse, and no bus activity takes place.

The request port is valid/ready. The master holds its request fields stable while `req_valid` is high and `req_ready` is low, and the transfer happens on a clock edge where both are high. `req_ready` is low from the accepting edge until the unit is idle again. The response side has no back-pressure: `rsp_valid` lasts exactly one cycle and the master must take the data then.

Top module: `lane_align_unit`

## Requirements
- R1: `req_ready` is high only while the unit is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. In the following cycle, exactly one of `bus_act` or `align_err` is high, and only for that one cycle. A request offered while `req_ready` is low has no effect.
- R2: During the bus phase, `bus_addr` equals the request address with bits 1 and 0 forced to zero.
- R3: A byte access at offset n (address bits 1:0) targets lane 3-n. Lane 3 is data bits 31:24 and lane 0 is bits 7:0, and `bus_lane_n[k]` is the active-low strobe for lane k.
- R4: A word access at offset 0 targets lanes 3 and 2. A word access at offset 2 targets lanes 1 and 0.
- R5: A longword access at offset 0 targets all four lanes.
- R6: With `strobe_mode` = 0, the target lanes' strobes go low on writes only. Reads keep all four lane strobes high, and `bus_we_n` stays high in this mode.
- R7: With `strobe_mode` = 1, the target lanes' strobes go low on both reads and writes, and `bus_we_n` goes low during write bus phases only.
- R8: On a write, byte k of the access (counting from the lowest address) carries `req_wdata` byte (size-1-k), where byte 0 is bits 7:0. The data is placed on the lane that R3 to R5 assign to that byte.
- R9: On a read, `rsp_valid` is high for one cycle, in the cycle right after the bus phase. `rsp_rdata` holds the target lanes with the lowest-addressed byte most significant, shifted down to bit 0 and zero-extended.
- R10: An access is misaligned if it is a word at an odd offset, a longword at a nonzero offset, or uses size code 3. A misaligned access raises `align_err` for one cycle in place of a bus phase. During that cycle all strobes are high, `bus_act` is low, and no response follows.
- R11: Under reset, `req_ready` is high, `bus_act`, `align_err` and `rsp_valid` are low, and all strobes are high.
- R12: Size encoding on `req_size`: 0 is byte, 1 is word, 2 is longword, 3 is reserved. `strobe_mode` is sampled on the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Unit idle, request may be taken |
| req_addr | input | AW (26) | Byte address |
| req_size | input | 2 | Transfer size code |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DW (32) | Right-justified write data |
| strobe_mode | input | 1 | 0 = per-lane write enables, 1 = lane select plus common write strobe |
| bus_addr | output | AW (26) | Longword-aligned bus address |
| bus_act | output | 1 | High for the single bus phase |
| bus_lane_n | output | DW/8 (4) | Active-low lane strobes |
| bus_we_n | output | 1 | Active-low common write strobe |
| bus_wdata | output | DW (32) | Lane-steered write data |
| bus_rdata | input | DW (32) | Data returned by the bus |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_rdata | output | DW (32) | Right-justified, zero-extended read data |
| align_err | output | 1 | Misaligned request pulse |

## Verification
The properties assume that the master keeps its request fields steady while a request waits, that `bus_rdata` is settled by the clock edge that closes the bus phase, and that reset is released between clock edges. The bench drives its inputs only on falling edges, moves to new request fields only after the handshake has completed, and derives `bus_rdata` from `bus_addr` as a fixed function, so the returned word stays steady for the whole bus phase. Back-to-back requests keep `req_valid` high through busy cycles. This shows that a waiting request stays pending and is not taken early.

// File: rtl/lane_align_pkg.sv
package lane_align_pkg;

  // Transfer size codes on the request port
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_RSVD = 2'd3
  } xfer_size_e;

  // Sequencer states
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUS  = 2'd1,
    ST_RESP = 2'd2,
    ST_ERR  = 2'd3
  } seq_state_e;

  // Number of bytes moved by a size code; reserved maps to 1 so the
  // caller can still take a modulo without a zero divisor.
  function automatic int size_bytes(input logic [1:0] sz);
    case (sz)
      SZ_BYTE: return 1;
      SZ_WORD: return 2;
      SZ_LONG: return 4;
      default: return 1;
    endcase
  endfunction

endpackage

// File: rtl/lane_decode.sv
module lane_decode
  import lane_align_pkg::*;
#(
  parameter int NL = 4,
  parameter int OB = 2
) (
  input  logic [OB-1:0] off,
  input  logic [1:0]    size,
  output logic [NL-1:0] lane_sel,
  output logic          misalign
);

  int nb_i;
  int off_i;
  logic rsvd;

  always_comb begin
    rsvd  = (size == SZ_RSVD);
    nb_i  = size_bytes(size);
    off_i = int'(off);
    misalign = rsvd || (nb_i > NL) || ((off_i % nb_i) != 0);
  end

  // Big-endian: byte offset b sits on lane NL-1-b
  for (genvar i = 0; i < NL; i++) begin : g_lane
    localparam int BYTE_IDX = NL - 1 - i;
    always_comb begin
      lane_sel[i] = !misalign && (BYTE_IDX >= off_i) && (BYTE_IDX < off_i + nb_i);
    end
  end

endmodule

// File: rtl/wr_steer.sv
module wr_steer
  import lane_align_pkg::*;
#(
  parameter int NL = 4
) (
  input  logic [1:0]      size,
  input  logic [8*NL-1:0] wdata,
  output logic [8*NL-1:0] lanes
);

  // Replicate the right-justified operand across the bus so the
  // addressed lanes always hold the right bytes whatever the offset.
  for (genvar i = 0; i < NL; i++) begin : g_lane
    localparam int WORD_SRC = i % 2;
    localparam int LONG_SRC = i % 4;
    always_comb begin
      case (size)
        SZ_BYTE: lanes[8*i +: 8] = wdata[7:0];
        SZ_WORD: lanes[8*i +: 8] = wdata[8*WORD_SRC +: 8];
        default: lanes[8*i +: 8] = wdata[8*LONG_SRC +: 8];
      endcase
    end
  end

endmodule

// File: rtl/rd_extract.sv
module rd_extract
  import lane_align_pkg::*;
#(
  parameter int NL = 4,
  parameter int OB = 2
) (
  input  logic [8*NL-1:0] rdata,
  input  logic [OB-1:0]   off,
  input  logic [1:0]      size,
  output logic [8*NL-1:0] data
);

  int nb_i;
  int sh_i;
  logic [8*NL-1:0] keep;
  logic [8*NL-1:0] shifted;

  always_comb begin
    nb_i = size_bytes(size);
    sh_i = NL - int'(off) - nb_i;
    if (sh_i < 0) sh_i = 0;
    for (int k = 0; k < NL; k++) begin
      keep[8*k +: 8] = (k < nb_i) ? 8'hFF : 8'h00;
    end
    shifted = rdata >> (8 * sh_i);
    data    = shifted & keep;
  end

endmodule

// File: rtl/lane_align_unit.sv
module lane_align_unit
  import lane_align_pkg::*;
#(
  parameter int AW = 26,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic [1:0]    req_size,
  input  logic          req_write,
  input  logic [DW-1:0] req_wdata,
  input  logic          strobe_mode,
  output logic [AW-1:0] bus_addr,
  output logic          bus_act,
  output logic [DW/8-1:0] bus_lane_n,
  output logic          bus_we_n,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic          align_err
);

  localparam int NL = DW / 8;
  localparam int OB = $clog2(NL);

  seq_state_e state_q;
  logic [NL-1:0] sel;
  logic          misalign;
  logic [DW-1:0] steered;
  logic [DW-1:0] extracted;
  logic          accept;
  logic [NL-1:0] lane_active;

  logic [AW-1:0] addr_q;
  logic [NL-1:0] lane_n_q;
  logic          we_n_q;
  logic [DW-1:0] wdata_q;
  logic          is_read_q;
  logic [OB-1:0] off_q;
  logic [1:0]    size_q;
  logic [DW-1:0] rdata_q;

  lane_decode #(.NL(NL), .OB(OB)) u_decode (
    .off      (req_addr[OB-1:0]),
    .size     (req_size),
    .lane_sel (sel),
    .misalign (misalign)
  );

  wr_steer #(.NL(NL)) u_steer (
    .size  (req_size),
    .wdata (req_wdata),
    .lanes (steered)
  );

  rd_extract #(.NL(NL), .OB(OB)) u_extract (
    .rdata (bus_rdata),
    .off   (off_q),
    .size  (size_q),
    .data  (extracted)
  );

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;

  always_comb begin
    if (strobe_mode) lane_active = sel;
    else if (req_write) lane_active = sel;
    else lane_active = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      addr_q    <= '0;
      lane_n_q  <= '1;
      we_n_q    <= 1'b1;
      wdata_q   <= '0;
      is_read_q <= 1'b0;
      off_q     <= '0;
      size_q    <= SZ_BYTE;
      rdata_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            if (misalign) begin
              state_q <= ST_ERR;
            end else begin
              state_q   <= ST_BUS;
              addr_q    <= {req_addr[AW-1:OB], {OB{1'b0}}};
              lane_n_q  <= ~lane_active;
              we_n_q    <= ~(strobe_mode && req_write);
              wdata_q   <= steered;
              is_read_q <= ~req_write;
              off_q     <= req_addr[OB-1:0];
              size_q    <= req_size;
            end
          end
        end
        ST_BUS: begin
          lane_n_q <= '1;
          we_n_q   <= 1'b1;
          if (is_read_q) begin
            rdata_q <= extracted;
            state_q <= ST_RESP;
          end else begin
            state_q <= ST_IDLE;
          end
        end
        ST_RESP: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign bus_addr   = addr_q;
  assign bus_act    = (state_q == ST_BUS);
  assign bus_lane_n = lane_n_q;
  assign bus_we_n   = we_n_q;
  assign bus_wdata  = wdata_q;
  assign rsp_valid  = (state_q == ST_RESP);
  assign rsp_rdata  = rdata_q;
  assign align_err  = (state_q == ST_ERR);

endmodule

// File: rtl/lane_align_checker.sv
module lane_align_checker #(
  parameter int AW = 26,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic [AW-1:0] bus_addr,
  input logic          bus_act,
  input logic [DW/8-1:0] bus_lane_n,
  input logic          bus_we_n,
  input logic          rsp_valid,
  input logic          align_err
);

  p_single_outcome_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (bus_act != align_err));

  p_busy_not_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_act || align_err || rsp_valid) |-> !req_ready);

  p_phase_once_r1: assert property (@(posedge clk) disable iff (!rst_n)
    bus_act |=> !bus_act);

  p_addr_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_act |-> (bus_addr[1:0] == 2'b00));

  p_lanes_in_phase_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_lane_n != '1) |-> bus_act);

  p_we_in_phase_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_we_n |-> bus_act);

  p_write_lane_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_act && !bus_we_n) |-> ($countones(~bus_lane_n) == 1 ||
                                $countones(~bus_lane_n) == 2 ||
                                $countones(~bus_lane_n) == 4));

  p_rsp_after_phase_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(bus_act));

  p_err_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    align_err |-> (bus_lane_n == '1 && bus_we_n && !bus_act));

  p_err_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    align_err |=> (!align_err && !rsp_valid));

  p_outcomes_exclusive_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({bus_act, align_err, rsp_valid}));

endmodule

bind lane_align_unit lane_align_checker #(.AW(AW), .DW(DW)) u_lane_align_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .bus_addr   (bus_addr),
  .bus_act    (bus_act),
  .bus_lane_n (bus_lane_n),
  .bus_we_n   (bus_we_n),
  .rsp_valid  (rsp_valid),
  .align_err  (align_err)
);

// File: tb/test_lane_align_unit.sv
`timescale 1ns/1ps
module test_lane_align_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [25:0] req_addr = '0;
  logic [1:0]  req_size = 2'd0;
  logic        req_write = 1'b0;
  logic [31:0] req_wdata = '0;
  logic        strobe_mode = 1'b0;
  logic [25:0] bus_addr;
  logic        bus_act;
  logic [3:0]  bus_lane_n;
  logic        bus_we_n;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        align_err;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #10 clk = ~clk;   // 50 MHz

  function automatic logic [31:0] memval(input logic [25:0] a);
    return {a[15:0], ~a[15:0]} ^ 32'h5A3C_96E1;
  endfunction

  assign bus_rdata = memval(bus_addr);

  lane_align_unit i_lane_align_unit (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_size(req_size), .req_write(req_write),
    .req_wdata(req_wdata), .strobe_mode(strobe_mode),
    .bus_addr(bus_addr), .bus_act(bus_act), .bus_lane_n(bus_lane_n),
    .bus_we_n(bus_we_n), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .align_err(align_err)
  );

  // ---------------- reference model ----------------
  logic        m_ready, m_act, m_err, m_rsp, m_we, m_wr;
  logic [3:0]  m_lanes, m_amask;
  logic [25:0] m_addr;
  logic [31:0] m_wd, m_rdata;
  int          m_off, m_nb;
  string       m_ltag;

  function automatic int nbytes_of(input logic [1:0] s);
    return (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : (s == 2'd2) ? 4 : 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ready = 1; m_act = 0; m_err = 0; m_rsp = 0; m_we = 1; m_wr = 0;
      m_lanes = 4'hF; m_amask = 0; m_addr = 0; m_wd = 0; m_rdata = 0;
      m_off = 0; m_nb = 1; m_ltag = "R11";
    end else begin
      logic nrsp;
      logic acc;
      int nb, off;
      nrsp = m_act && !m_wr;
      if (nrsp) begin
        logic [31:0] w;
        w = memval(m_addr);
        m_rdata = 0;
        for (int k = 0; k < m_nb; k++)
          m_rdata[8*(m_nb-1-k) +: 8] = w[8*(3-(m_off+k)) +: 8];
      end
      acc = req_valid && m_ready;
      m_act = 0; m_err = 0; m_lanes = 4'hF; m_we = 1;
      if (acc) begin
        nb  = nbytes_of(req_size);
        off = int'(req_addr[1:0]);
        if (nb == 0 || (off % nb) != 0) begin
          m_err = 1;
        end else begin
          m_act = 1; m_wr = req_write; m_off = off; m_nb = nb;
          m_addr = {req_addr[25:2], 2'b00};
          m_amask = 0; m_wd = 0;
          for (int k = 0; k < nb; k++) begin
            m_amask[3-(off+k)] = 1'b1;
            m_wd[8*(3-(off+k)) +: 8] = req_wdata[8*(nb-1-k) +: 8];
          end
          if (strobe_mode || req_write) m_lanes = ~m_amask;
          m_we = !(strobe_mode && req_write);
          if (!strobe_mode && !req_write) m_ltag = "R6";
          else if (nb == 1) m_ltag = "R3";
          else if (nb == 2) m_ltag = "R4";
          else m_ltag = "R5";
        end
      end
      m_rsp = nrsp;
      m_ready = !(m_act || m_err || m_rsp);
    end
  end

  // ---------------- comparison ----------------
  task automatic chk(input logic ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (!rst_n) begin
      // R11 reset state
      chk(req_ready === 1'b1, "R11", "ready", {31'd0, req_ready}, 32'd1);
      chk(bus_act === 1'b0 && align_err === 1'b0 && rsp_valid === 1'b0, "R11", "pulses",
          {29'd0, bus_act, align_err, rsp_valid}, 32'd0);
      chk(bus_lane_n === 4'hF && bus_we_n === 1'b1, "R11", "strobes",
          {27'd0, bus_we_n, bus_lane_n}, 32'h1F);
    end else begin
      chk(req_ready === m_ready, "R1", "req_ready", {31'd0, req_ready}, {31'd0, m_ready});
      chk(bus_act === m_act, "R1", "bus_act", {31'd0, bus_act}, {31'd0, m_act});
      chk(align_err === m_err, "R10", "align_err", {31'd0, align_err}, {31'd0, m_err});
      chk(rsp_valid === m_rsp, "R9", "rsp_valid", {31'd0, rsp_valid}, {31'd0, m_rsp});
      chk(bus_we_n === m_we, "R7", "bus_we_n", {31'd0, bus_we_n}, {31'd0, m_we});
      chk(bus_lane_n === m_lanes, m_act ? m_ltag : "R10", "bus_lane_n",
          {28'd0, bus_lane_n}, {28'd0, m_lanes});
      if (m_act)
        chk(bus_addr === m_addr, "R2", "bus_addr", {6'd0, bus_addr}, {6'd0, m_addr});
      if (m_act && m_wr)
        for (int l = 0; l < 4; l++)
          if (m_amask[l])
            chk(bus_wdata[8*l +: 8] === m_wd[8*l +: 8], "R8", "bus_wdata lane",
                {24'd0, bus_wdata[8*l +: 8]}, {24'd0, m_wd[8*l +: 8]});
      if (m_rsp)
        chk(rsp_rdata === m_rdata, "R9", "rsp_rdata", rsp_rdata, m_rdata);
    end
  end

  // ---------------- stimulus ----------------
  task automatic send(input logic [25:0] a, input logic [1:0] sz, input logic wr,
                      input logic [31:0] wd, input logic md);
    logic rdy;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_size = sz; req_write = wr;
    req_wdata = wd; strobe_mode = md;
    forever begin
      rdy = req_ready;
      @(posedge clk);
      if (rdy) break;
      @(negedge clk);
    end
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    req_valid = 1'b0;
    req_wdata = 32'hDEAD_BEEF;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int seq;
    seq = 0;
    repeat (3) @(negedge clk);
    #3 rst_n = 1'b1;
    // R12 size codes, both modes (R6, R7), all legal offsets (R3, R4, R5), R8, R9
    for (int md = 0; md < 2; md++) begin
      for (int wr = 0; wr < 2; wr++) begin
        for (int sz = 0; sz < 3; sz++) begin
          for (int off = 0; off < 4; off++) begin
            logic [25:0] a;
            seq++;
            a = (26'(seq) * 26'h0_1234_5 + 26'h3_0000) & 26'h3FF_FFFC;
            a[1:0] = 2'(off);
            send(a, 2'(sz), wr[0], 32'h1122_3344 ^ (32'(seq) * 32'h0101_0307), md[0]);
          end
        end
        idle(2);
      end
    end
    // R10 reserved size, then back-to-back legal traffic with valid held high (R1)
    send(26'h000_0100, 2'd3, 1'b1, 32'hCAFE_F00D, 1'b1);
    send(26'h000_0201, 2'd0, 1'b0, 32'h0, 1'b1);
    send(26'h000_0302, 2'd1, 1'b1, 32'h0000_ABCD, 1'b0);
    send(26'h3FF_FFFF, 2'd0, 1'b0, 32'h0, 1'b0);
    send(26'h3FF_FFFE, 2'd2, 1'b0, 32'h0, 1'b1);
    send(26'h3FF_FFFC, 2'd2, 1'b1, 32'h89AB_CDEF, 1'b1);
    idle(4);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    wait (cycles > 20000);
    fails++; checks++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule